// File: doc/BRIEF.md
# Port Parity Generator and Checker

This block sits beside the two data ports of a buffered transfer path and watches the 36-bit words that cross each port. Each word is split into four lanes of nine bits: eight data bits and one parity bit above them. On every edge of a port's own clock, the block records whether any lane on that port's bus breaks the selected parity rule. It reports the result on an active-low error flag for that port. The check is passive. It never holds back, delays or alters a word, so a system that does not use parity can simply leave the flags unconnected.

Each port also has an outgoing read path. When generation is enabled for a port, the block writes freshly computed parity into the four parity positions of the outgoing word and passes the data bits through untouched. When generation is disabled, the stored word goes out bit for bit. A single sense input selects odd or even parity for checking and for generation on both ports.

Top module: `port_parity_unit`

## Requirements
- R1: While `rst_n` is low, both `a_perr_n` and `b_perr_n` are 1.
- R2: One rising edge of `clk_a` after `a_bus` carries a word in which any lane fails the selected parity, `a_perr_n` reads 0. After an edge with all four lanes correct, it reads 1. Lane i occupies bits 9i+8..9i, and bit 9i+8 is its parity bit.
- R3: `b_perr_n` follows `b_bus` in the same way on `clk_b`. It is unaffected by the contents of `a_bus`, and `a_perr_n` is unaffected by the contents of `b_bus`.
- R4: With `odd_sel`=0 a lane is correct when its nine bits hold an even number of ones. With `odd_sel`=1 a lane is correct when they hold an odd number of ones.
- R5: With `a_gen_en`=1, `a_rd_out` equals `a_rd_raw` on the 32 data bits. Each parity position 9i+8 is set so that lane i meets the parity that `odd_sel` selects. `b_gen_en` does the same for `b_rd_out`.
- R6: With generation disabled, the read output equals the raw read word exactly, even when that word has bad parity or the port's flag is low.
- R7: Each port's generation enable affects only that port's read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, may be unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | Parity sense: 1 odd, 0 even |
| a_bus | input | 36 | Word seen on port A bus, checked |
| a_gen_en | input | 1 | Generate parity on port A read data |
| a_rd_raw | input | 36 | Stored word leaving through port A |
| a_rd_out | output | 36 | Port A read word after optional generation |
| a_perr_n | output | 1 | Port A parity error flag, active low |
| b_bus | input | 36 | Word seen on port B bus, checked |
| b_gen_en | input | 1 | Generate parity on port B read data |
| b_rd_raw | input | 36 | Stored word leaving through port B |
| b_rd_out | output | 36 | Port B read word after optional generation |
| b_perr_n | output | 1 | Port B parity error flag, active low |

## Verification
The embedded assertions check the read paths on every clock edge. With generation on, every outgoing lane meets the selected parity and keeps its data bits. With generation off, the outgoing word is identical to the stored word. The registered flags, their timing relative to each port's own clock, and the separation between the two ports are covered only by the bench scenarios. Those scenarios corrupt one lane at a time, flip the sense input and drive one port bad while the other stays clean.

// File: rtl/port_parity_unit.sv
module port_parity_unit #(
  parameter int BYTES     = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic                               clk_a,
  input  logic                               clk_b,
  input  logic                               rst_n,
  input  logic                               odd_sel,
  input  logic [BYTES*(BYTE_BITS+1)-1:0]     a_bus,
  input  logic                               a_gen_en,
  input  logic [BYTES*(BYTE_BITS+1)-1:0]     a_rd_raw,
  output logic [BYTES*(BYTE_BITS+1)-1:0]     a_rd_out,
  output logic                               a_perr_n,
  input  logic [BYTES*(BYTE_BITS+1)-1:0]     b_bus,
  input  logic                               b_gen_en,
  input  logic [BYTES*(BYTE_BITS+1)-1:0]     b_rd_raw,
  output logic [BYTES*(BYTE_BITS+1)-1:0]     b_rd_out,
  output logic                               b_perr_n
);

  localparam int LANE = BYTE_BITS + 1;

  logic [BYTES-1:0] a_lane_bad, b_lane_bad;
  logic [BYTES*LANE-1:0] a_gen_word, b_gen_word;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign a_lane_bad[i] = (^a_bus[i*LANE +: LANE]) != odd_sel;
    assign b_lane_bad[i] = (^b_bus[i*LANE +: LANE]) != odd_sel;

    assign a_gen_word[i*LANE +: BYTE_BITS]  = a_rd_raw[i*LANE +: BYTE_BITS];
    assign a_gen_word[i*LANE + BYTE_BITS]   = (^a_rd_raw[i*LANE +: BYTE_BITS]) ^ odd_sel;
    assign b_gen_word[i*LANE +: BYTE_BITS]  = b_rd_raw[i*LANE +: BYTE_BITS];
    assign b_gen_word[i*LANE + BYTE_BITS]   = (^b_rd_raw[i*LANE +: BYTE_BITS]) ^ odd_sel;

    AST_A_GEN_PARITY: assert property (@(posedge clk_a) disable iff (!rst_n)
      a_gen_en |-> ((^a_rd_out[i*LANE +: LANE]) == odd_sel)); // R5
    AST_A_GEN_DATA: assert property (@(posedge clk_a) disable iff (!rst_n)
      a_gen_en |-> (a_rd_out[i*LANE +: BYTE_BITS] == a_rd_raw[i*LANE +: BYTE_BITS])); // R5
    AST_B_GEN_PARITY: assert property (@(posedge clk_b) disable iff (!rst_n)
      b_gen_en |-> ((^b_rd_out[i*LANE +: LANE]) == odd_sel)); // R5
    AST_B_GEN_DATA: assert property (@(posedge clk_b) disable iff (!rst_n)
      b_gen_en |-> (b_rd_out[i*LANE +: BYTE_BITS] == b_rd_raw[i*LANE +: BYTE_BITS])); // R5
  end

  assign a_rd_out = a_gen_en ? a_gen_word : a_rd_raw;
  assign b_rd_out = b_gen_en ? b_gen_word : b_rd_raw;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) a_perr_n <= 1'b1;
    else        a_perr_n <= ~|a_lane_bad;

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) b_perr_n <= 1'b1;
    else        b_perr_n <= ~|b_lane_bad;

  AST_A_PASSTHRU: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_gen_en |-> (a_rd_out == a_rd_raw)); // R6
  AST_B_PASSTHRU: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_gen_en |-> (b_rd_out == b_rd_raw)); // R6

endmodule

// File: tb/port_parity_unit_bench.sv
module port_parity_unit_bench;
  logic clk_a = 0, clk_b = 0, rst_n = 0, odd_sel = 0;
  logic [35:0] a_bus = '0, a_rd_raw = '0, b_bus = '0, b_rd_raw = '0;
  logic a_gen_en = 0, b_gen_en = 0;
  logic [35:0] a_rd_out, b_rd_out;
  logic a_perr_n, b_perr_n;
  int checks = 0, errors = 0;
  bit done = 0;

  port_parity_unit u_port_parity_unit (.*);

  always #2 clk_a = ~clk_a;
  initial begin #1; forever #2 clk_b = ~clk_b; end

  function automatic logic [35:0] mk(input logic [31:0] d, input logic odd, input logic [3:0] bad);
    logic [35:0] w;
    for (int i = 0; i < 4; i++) begin
      w[9*i +: 8] = d[8*i +: 8];
      w[9*i + 8]  = (^d[8*i +: 8]) ^ odd ^ bad[i];
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick_a(); @(posedge clk_a); #1; endtask
  task automatic tick_b(); @(posedge clk_b); #1; endtask

  task automatic t_reset();
    rst_n = 0;
    a_bus = mk(32'h1234_5678, 0, 4'hF);
    b_bus = mk(32'h9abc_def0, 0, 4'hF);
    tick_a(); tick_b();
    chk("R1 a_perr_n in reset", a_perr_n, 1);
    chk("R1 b_perr_n in reset", b_perr_n, 1);
    a_bus = mk(32'h1234_5678, 0, 0);
    b_bus = mk(32'h9abc_def0, 0, 0);
    rst_n = 1;
    tick_a(); tick_b();
  endtask

  task automatic t_port_a();
    odd_sel = 0;
    a_bus = mk(32'hdead_beef, 0, 0); tick_a();
    chk("R2 a good word", a_perr_n, 1);
    for (int i = 0; i < 4; i++) begin
      a_bus = mk(32'hdead_beef, 0, 4'b1 << i); tick_a();
      chk($sformatf("R2 a bad lane %0d", i), a_perr_n, 0);
    end
    a_bus = mk(32'h0000_0000, 0, 0); tick_a();
    chk("R2 a recovers", a_perr_n, 1);
  endtask

  task automatic t_port_b();
    a_bus = mk(32'h5555_aaaa, 0, 0);
    b_bus = mk(32'h0f0f_f0f0, 0, 4'b0100); tick_b(); tick_a();
    chk("R3 b bad lane", b_perr_n, 0);
    chk("R3 a unaffected by b", a_perr_n, 1);
    b_bus = mk(32'h0f0f_f0f0, 0, 0);
    a_bus = mk(32'h5555_aaaa, 0, 4'b0001); tick_b(); tick_a();
    chk("R3 b good", b_perr_n, 1);
    chk("R3 a bad while b good", a_perr_n, 0);
    a_bus = mk(32'h5555_aaaa, 0, 0); tick_a();
  endtask

  task automatic t_sense();
    odd_sel = 1;
    a_bus = mk(32'h0102_0304, 0, 0);
    b_bus = mk(32'h0102_0304, 1, 0); tick_a(); tick_b();
    chk("R4 even word under odd sense", a_perr_n, 0);
    chk("R4 odd word under odd sense", b_perr_n, 1);
    odd_sel = 0; tick_a(); tick_b();
    chk("R4 even word under even sense", a_perr_n, 1);
    chk("R4 odd word under even sense", b_perr_n, 0);
    b_bus = mk(32'h0102_0304, 0, 0); tick_b();
  endtask

  task automatic t_gen();
    a_gen_en = 1; b_gen_en = 1;
    a_rd_raw = mk(32'hcafe_f00d, 0, 4'hF);
    b_rd_raw = mk(32'h8421_1248, 1, 4'b1010);
    odd_sel = 0; #1;
    chk("R5 a gen even", a_rd_out, mk(32'hcafe_f00d, 0, 0));
    chk("R5 b gen even", b_rd_out, mk(32'h8421_1248, 0, 0));
    odd_sel = 1; #1;
    chk("R5 a gen odd", a_rd_out, mk(32'hcafe_f00d, 1, 0));
    chk("R5 b gen odd", b_rd_out, mk(32'h8421_1248, 1, 0));
    tick_a(); odd_sel = 0;
  endtask

  task automatic t_pass();
    a_gen_en = 0; b_gen_en = 0;
    a_rd_raw = mk(32'h1357_9bdf, 0, 4'b0110);
    a_bus = mk(32'h1357_9bdf, 0, 4'b0110); tick_a();
    chk("R6 a flag low during passthru", a_perr_n, 0);
    chk("R6 a raw passes", a_rd_out, mk(32'h1357_9bdf, 0, 4'b0110));
    b_rd_raw = 36'h9_ffff_ffff; #1;
    chk("R6 b raw passes", b_rd_out, 36'h9_ffff_ffff);
    a_bus = mk(32'h1357_9bdf, 0, 0); tick_a();
  endtask

  task automatic t_indep();
    a_gen_en = 1; b_gen_en = 0;
    a_rd_raw = mk(32'h2468_ace0, 0, 4'hF);
    b_rd_raw = mk(32'h2468_ace0, 0, 4'hF); #1;
    chk("R7 a gen on", a_rd_out, mk(32'h2468_ace0, 0, 0));
    chk("R7 b untouched by a_gen_en", b_rd_out, mk(32'h2468_ace0, 0, 4'hF));
    a_gen_en = 0; b_gen_en = 1; #1;
    chk("R7 a untouched by b_gen_en", a_rd_out, mk(32'h2468_ace0, 0, 4'hF));
    chk("R7 b gen on", b_rd_out, mk(32'h2468_ace0, 0, 0));
  endtask

  initial begin
    t_reset();
    t_port_a();
    t_port_b();
    t_sense();
    t_gen();
    t_pass();
    t_indep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule